// File: doc/BRIEF.md
# SDLC Frame Address Filter

This block sits behind the deframer of a bit-oriented synchronous receiver and judges each frame by its address byte, which is the first byte delivered after the opening flag. If the address is acceptable, the rest of the frame is forwarded. Otherwise every byte of the frame is dropped, and the receiver's interrupts stay closed until the frame ends.

Two comparison widths are offered. Exact mode matches the full address byte, so one address in 256 is accepted. Partial mode matches only the upper nibble, so sixteen addresses in 256 are accepted. The all-ones broadcast address is accepted in either mode. Filtering is active only while both the bit-oriented protocol select and the search enable are high. In any other case the block forwards every byte and leaves interrupts open.

The controller has four states. `ST_IDLE` means no frame is open. `ST_WAIT` means a frame has opened and its address byte has not yet arrived. `ST_ACCEPT` and `ST_REJECT` hold the decision for the current frame. The transitions are as follows:
- start-of-frame without a byte: `ST_IDLE`/`ST_ACCEPT`/`ST_REJECT` → `ST_WAIT`.
- the address byte (a valid byte in the start-of-frame cycle or in `ST_WAIT`): → `ST_ACCEPT` on a hit, → `ST_REJECT` on a miss.
- end-of-frame or abort, from any state: → `ST_IDLE`. This has priority over every other transition.
- no event: the current state is held.

Top module: `sdlc_addr_filter`

## Requirements
- R1: With the match width select low, an address byte equal to all 8 bits of the address register accepts the frame, and any other non-broadcast byte rejects it.
- R2: With the match width select high, only bits [7:4] of the address byte are compared with bits [7:4] of the address register, so 16 of the 256 addresses are accepted.
- R3: The address byte 8'hFF accepts the frame in both match widths.
- R4: In a rejected frame, no byte is forwarded. This includes the address byte, the payload and the closing byte.
- R5: While filtering is active, the interrupt gate is high only in `ST_ACCEPT`. The gate therefore rises in the cycle after an accepted address byte and is low while idle, while waiting and while rejecting.
- R6: The decision is held until end-of-frame or abort. A byte that arrives with end-of-frame is judged by the held decision. Afterwards the filter returns to `ST_IDLE`, and the next frame's address byte is judged afresh.
- R7: With the protocol select low, every byte is forwarded and the interrupt gate is high, whatever the search enable is.
- R8: With the search enable low, every byte is forwarded and the interrupt gate is high.
- R9: A forwarded byte appears on the output valid and data one clock after its input cycle, with the data unchanged.
- R10: The address byte may arrive together with the start-of-frame marker or in any later cycle. While filtering is active, a byte that arrives with no frame open is not forwarded.
- R11: After reset the filter is in `ST_IDLE` and the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdlc_mode | input | 1 | Bit-oriented protocol select; filtering needs this high |
| srch_en | input | 1 | Address search enable |
| wide_match | input | 1 | 1: compare upper nibble only; 0: compare the full byte |
| addr_reg | input | 8 | Programmed station address |
| sof | input | 1 | Start-of-frame marker (opening flag seen) |
| eof | input | 1 | End-of-frame marker; a byte in the same cycle is the frame's last byte |
| abort | input | 1 | Abort marker; closes the frame |
| byte_vld | input | 1 | Received byte valid |
| byte_data | input | 8 | Received byte |
| pass_vld | output | 1 | Forwarded byte valid, one cycle after input |
| pass_data | output | 8 | Forwarded byte |
| irq_gate | output | 1 | High when receiver interrupts may be raised |

## Verification
On every cycle, the assertions check four things. A frame in `ST_REJECT` forwards nothing. A held decision does not change until the frame closes. End-of-frame and abort always return the filter to `ST_IDLE`. A bypassed byte emerges one cycle later with the same data. The assertions also check that a broadcast or mismatching address byte leads to the correct state. Only the bench's scenarios can show the following: the full accept set of both widths across all 256 addresses for several register values, that a later frame is judged afresh after an abort, the exact cycle in which the interrupt gate opens, and that stray bytes between frames are dropped.

// File: rtl/sdlc_af_pkg.sv
package sdlc_af_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACCEPT = 2'd2,
        ST_REJECT = 2'd3
    } af_state_e;
endpackage

// File: rtl/af_addr_match.sv
module af_addr_match #(
    parameter int W  = 8,
    parameter int PW = 4
) (
    input  logic [W-1:0] addr_byte,
    input  logic [W-1:0] addr_reg,
    input  logic         wide,
    output logic         hit
);
    localparam int LO = W - PW;

    logic bcast;
    logic full_eq;
    logic part_eq;

    assign bcast   = (addr_byte == {W{1'b1}});
    assign full_eq = (addr_byte == addr_reg);

    generate
        if (PW >= W) begin : g_part_full
            assign part_eq = full_eq;
        end else begin : g_part_hi
            assign part_eq = (addr_byte[W-1:LO] == addr_reg[W-1:LO]);
        end
    endgenerate

    assign hit = bcast || (wide ? part_eq : full_eq);
endmodule

// File: rtl/af_frame_fsm.sv
module af_frame_fsm
    import sdlc_af_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sof,
    input  logic      eof,
    input  logic      abort,
    input  logic      byte_vld,
    input  logic      hit,
    output af_state_e state,
    output logic      addr_cycle
);
    af_state_e nxt;
    logic      ev_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        ev_end     = eof || abort;
        addr_cycle = byte_vld && (sof || (state == ST_WAIT));
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_ACCEPT, ST_REJECT: begin
                if (ev_end)          nxt = ST_IDLE;
                else if (addr_cycle) nxt = hit ? ST_ACCEPT : ST_REJECT;
                else if (sof)        nxt = ST_WAIT;
                else                 nxt = state;
            end
            ST_WAIT: begin
                if (ev_end)          nxt = ST_IDLE;
                else if (addr_cycle) nxt = hit ? ST_ACCEPT : ST_REJECT;
                else                 nxt = ST_WAIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    p_close_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eof || abort) |=> (state == ST_IDLE));

    p_decision_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACCEPT || state == ST_REJECT) && !eof && !abort && !sof)
        |=> $stable(state));
endmodule

// File: rtl/af_stream_gate.sv
module af_stream_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_data,
    input  logic         keep,
    output logic         pass_vld,
    output logic [W-1:0] pass_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_vld  <= 1'b0;
            pass_data <= '0;
        end else begin
            pass_vld <= byte_vld && keep;
            if (byte_vld && keep) pass_data <= byte_data;
        end
    end

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !pass_vld);
endmodule

// File: rtl/sdlc_addr_filter.sv
module sdlc_addr_filter
    import sdlc_af_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdlc_mode,
    input  logic         srch_en,
    input  logic         wide_match,
    input  logic [W-1:0] addr_reg,
    input  logic         sof,
    input  logic         eof,
    input  logic         abort,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_data,
    output logic         pass_vld,
    output logic [W-1:0] pass_data,
    output logic         irq_gate
);
    af_state_e state;
    logic      hit;
    logic      addr_cycle;
    logic      filt_on;
    logic      keep;

    af_addr_match #(.W(W), .PW(PW)) u_match (
        .addr_byte (byte_data),
        .addr_reg  (addr_reg),
        .wide      (wide_match),
        .hit       (hit)
    );

    af_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .eof        (eof),
        .abort      (abort),
        .byte_vld   (byte_vld),
        .hit        (hit),
        .state      (state),
        .addr_cycle (addr_cycle)
    );

    always_comb begin
        filt_on  = sdlc_mode && srch_en;
        keep     = !filt_on || (addr_cycle ? hit : (state == ST_ACCEPT));
        irq_gate = !filt_on || (state == ST_ACCEPT);
    end

    af_stream_gate #(.W(W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .keep      (keep),
        .pass_vld  (pass_vld),
        .pass_data (pass_data)
    );

    p_reject_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_on && state == ST_REJECT && !sof) |=> !pass_vld);

    p_bypass_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !filt_on) |=> (pass_vld && pass_data == $past(byte_data)));

    p_broadcast_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cycle && byte_data == {W{1'b1}} && !eof && !abort)
        |=> (state == ST_ACCEPT));

    p_exact_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cycle && !wide_match && byte_data != addr_reg &&
         byte_data != {W{1'b1}} && !eof && !abort)
        |=> (state == ST_REJECT));
endmodule

// File: tb/tb_sdlc_addr_filter.sv
module tb_sdlc_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sdlc_mode, srch_en, wide_match;
    logic [7:0] addr_reg;
    logic       sof, eof, abort, byte_vld;
    logic [7:0] byte_data;
    logic       pass_vld;
    logic [7:0] pass_data;
    logic       irq_gate;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    sdlc_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .sdlc_mode(sdlc_mode), .srch_en(srch_en),
        .wide_match(wide_match), .addr_reg(addr_reg), .sof(sof), .eof(eof),
        .abort(abort), .byte_vld(byte_vld), .byte_data(byte_data),
        .pass_vld(pass_vld), .pass_data(pass_data), .irq_gate(irq_gate)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one cycle, then sample 5 ns after the rising edge
    task automatic step(input logic v, input logic [7:0] d,
                        input logic s, input logic e, input logic a);
        byte_vld = v; byte_data = d; sof = s; eof = e; abort = a;
        @(posedge clk);
        #5;
    endtask

    function automatic logic accepts(input logic [7:0] a, input logic [7:0] r,
                                     input logic w);
        if (a == 8'hFF) return 1'b1;
        if (w) return (a[7:4] == r[7:4]);
        return (a == r);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected done");
        n_fail++;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] regs [3];
        regs[0] = 8'h3C; regs[1] = 8'hA7; regs[2] = 8'h00;
        rst_n = 1'b0; sdlc_mode = 1'b1; srch_en = 1'b1; wide_match = 1'b0;
        addr_reg = 8'h3C;
        byte_vld = 1'b0; byte_data = 8'h00; sof = 1'b0; eof = 1'b0; abort = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R11 pass_vld in reset", int'(pass_vld), 0);
        rst_n = 1'b1;
        step(0, 8'h00, 0, 0, 0);
        check("R11 pass_vld after reset", int'(pass_vld), 0);
        check("R5 gate idle after reset", int'(irq_gate), 0);

        // sweep: mode 0 filtering, 1 protocol off, 2 search off
        for (int m = 0; m < 3; m++) begin
            sdlc_mode = (m != 1);
            srch_en   = (m != 2);
            for (int w = 0; w < 2; w++) begin
                wide_match = w[0];
                for (int ri = 0; ri < 3; ri++) begin
                    addr_reg = regs[ri];
                    for (int a = 0; a < 256; a++) begin
                        logic ex;
                        string tg;
                        ex = (m != 0) || accepts(a[7:0], regs[ri], w[0]);
                        tg = (m == 1) ? "R7" : (m == 2) ? "R8" :
                             (a == 255) ? "R3" : (w != 0) ? "R2" : "R1";
                        step(1, a[7:0], 1, 0, 0);
                        check({tg, " address byte pass"}, int'(pass_vld), int'(ex));
                        if (ex) check("R9 address data", int'(pass_data), a);
                        check({tg, " R5 gate after address"}, int'(irq_gate), int'(ex));
                        step(1, 8'h5A, 0, 0, 0);
                        check({tg, " R4 payload pass"}, int'(pass_vld), int'(ex));
                        if (ex) check("R9 payload data", int'(pass_data), 8'h5A);
                        step(1, 8'hC3, 0, 1, 0);
                        check({tg, " R6 closing byte pass"}, int'(pass_vld), int'(ex));
                        check({tg, " R6 gate after close"}, int'(irq_gate),
                              (m != 0) ? 1 : 0);
                    end
                end
            end
        end

        // directed: delayed address byte and stray byte (filtering on, exact)
        sdlc_mode = 1'b1; srch_en = 1'b1; wide_match = 1'b0; addr_reg = 8'h42;
        step(1, 8'h42, 0, 0, 0);
        check("R10 stray byte dropped", int'(pass_vld), 0);
        step(0, 8'h00, 1, 0, 0);
        check("R5 gate low while waiting", int'(irq_gate), 0);
        step(0, 8'h00, 0, 0, 0);
        check("R10 still waiting", int'(irq_gate), 0);
        step(1, 8'h42, 0, 0, 0);
        check("R10 late address pass", int'(pass_vld), 1);
        check("R5 gate opens on accept", int'(irq_gate), 1);
        step(0, 8'h00, 0, 1, 0);
        check("R6 gate closed after eof", int'(irq_gate), 0);

        // directed: abort re-arms, next frame judged afresh
        step(1, 8'h42, 1, 0, 0);
        check("R6 accepted frame", int'(irq_gate), 1);
        step(0, 8'h00, 0, 0, 1);
        check("R6 abort closes", int'(irq_gate), 0);
        step(1, 8'h43, 1, 0, 0);
        check("R6 new frame rejected", int'(pass_vld), 0);
        step(1, 8'h11, 0, 0, 0);
        check("R4 payload of rejected frame", int'(pass_vld), 0);
        check("R4 gate in reject", int'(irq_gate), 0);
        step(1, 8'hFF, 1, 0, 0);
        check("R3 broadcast after restart", int'(pass_vld), 1);
        check("R3 gate on broadcast", int'(irq_gate), 1);
        step(0, 8'h00, 0, 1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule